// File: doc/BRIEF.md
# Clocked Burst-Read Sequencer for NOR-Style Flash

This block models the clocked read path of a NOR-style flash device. An access starts when chip enable is low, write enable is high and the address strobe is low at a rising clock edge. At that edge the block captures the start address and a snapshot of the read configuration. After a fixed first-access latency, during which `wait_o` is high, it returns one data word per clock.

The configuration selects several things. It chooses whether synchronous bursts are allowed at all. It sets the burst length: 4, 8 or 16 words, or continuous. It chooses wrapping inside an aligned block or linear stepping. It also picks the data source: the behavioural array, or one of three non-array spaces (status, identifier, query). Raising chip enable ends any access on the next edge.

The output side is a valid-only stream. `rd_valid` marks each word and there is no ready input. A flash burst cannot be stalled, so the consumer must take every word in the cycle it is presented.

Top module: `flb_burst_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_valid` and `wait_o` are 0 and `rd_data` is 0 until the first access.
- R2: A low strobe starts nothing unless `cfg[0]` (synchronous enable) is 1, `ce_n` is 0 and `we_n` is 1 at that edge; otherwise `rd_valid` and `wait_o` stay 0.
- R3: The address is captured at the first rising edge that sees the strobe low. A strobe held low captures only once. Releasing it and driving it low again captures again.
- R4: `wait_o` is 1 from the edge after capture until the first word is presented. The first word has `rd_valid`=1 exactly LATENCY edges after the capture edge, and `wait_o` and `rd_valid` are never 1 together.
- R5: `cfg[2:1]` selects the length: 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 gives continuous. A fixed burst presents exactly that many words on consecutive cycles, then `rd_valid` drops and the block idles.
- R6: With `cfg[3]`=1 and a fixed length L, successive addresses step +1 within the L-aligned block and wrap to its start. Otherwise, including continuous bursts, they step +1 modulo 2^AW.
- R7: `cfg[5:4]` selects the word source. 0 gives the array, with word = address XOR 0xC3A5. 1 gives status, 0x0080. 2 gives identifier, 0x3C00 OR address[7:0]. 3 gives query, 0x5100 OR address[7:0].
- R8: `ce_n` high at an edge clears `rd_valid` and `wait_o` after that edge, whatever the state.
- R9: A new capture during a burst or during the latency restarts the access from the new address. It takes priority over the pending word, and `rd_valid` is 0 after that edge.
- R10: The configuration is sampled only at capture; changing `cfg` during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write enable, active low; blocks a start when low |
| addr | input | AW | Start address |
| cfg | input | 6 | [0] sync enable, [2:1] length code, [3] wrap, [5:4] source |
| rd_data | output | DW | Burst data word |
| rd_valid | output | 1 | Marks `rd_data` as a burst word |
| wait_o | output | 1 | High during the first-access latency |

## Verification
Two events can land on the same edge, and the bench forces both. The first is a new address capture and the last word of a fixed burst. The second is a held strobe being released for one cycle and then driven low again, while the previous access is still in its latency. In both cases the bench's cycle model gives the restart priority. It expects `rd_valid` low on that edge and the new stream LATENCY edges later. Output valid, data and wait are compared against that model on every clock.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} seq_state_e;
  typedef enum logic [1:0] {LEN_4, LEN_8, LEN_16, LEN_CONT} blen_e;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_QUERY} src_e;

  typedef struct packed {
    src_e  src;
    logic  wrap;
    blen_e len;
    logic  sync_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/flb_capture.sv
module flb_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic adv_n,
  input  logic we_n,
  input  logic sync_en,
  output logic start
);
  logic held_q;

  assign start = !ce_n && !adv_n && we_n && sync_en && !held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= 1'b0;
    else if (ce_n) held_q <= 1'b0;
    else           held_q <= !adv_n && (held_q || start);
  end

  AST_HELD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_n || ce_n) |=> !held_q); // R3
endmodule

// File: rtl/flb_addr_step.sv
module flb_addr_step
  import flb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  blen_e         len,
  input  logic          wrap,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  always_comb begin
    case (len)
      LEN_4:   mask = AW'(3);
      LEN_8:   mask = AW'(7);
      LEN_16:  mask = AW'(15);
      default: mask = '0;
    endcase
    inc = cur + AW'(1);
    if (wrap && len != LEN_CONT) nxt = (cur & ~mask) | (inc & mask);
    else                         nxt = inc;
  end
endmodule

// File: rtl/flb_word_src.sv
module flb_word_src
  import flb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  src_e          src,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  logic [DW-1:0] lo;
  assign lo = DW'(addr[7:0]);

  always_comb begin
    case (src)
      SRC_ARRAY:  word = DW'(addr) ^ DW'(16'hC3A5);
      SRC_STATUS: word = DW'(16'h0080);
      SRC_IDENT:  word = DW'(16'h3C00) | lo;
      default:    word = DW'(16'h5100) | lo;
    endcase
  end
endmodule

// File: rtl/flb_burst_seq.sv
module flb_burst_seq
  import flb_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int LATENCY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [5:0]    cfg,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wait_o
);
  localparam int LW = $clog2(LATENCY + 1);
  localparam int BW = 5;

  cfg_t          cfg_in, cfg_q;
  seq_state_e    st_q;
  logic [LW-1:0] lat_q;
  logic [AW-1:0] cur_q, nxt_addr;
  logic [BW-1:0] beat_q, len_words;
  logic [DW-1:0] word;
  logic          start;

  assign cfg_in = cfg_t'(cfg);

  flb_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .sync_en(cfg_in.sync_en), .start(start)
  );

  flb_addr_step #(.AW(AW)) u_step (
    .cur(cur_q), .len(cfg_q.len), .wrap(cfg_q.wrap), .nxt(nxt_addr)
  );

  flb_word_src #(.AW(AW), .DW(DW)) u_src (
    .src(cfg_q.src), .addr(cur_q), .word(word)
  );

  always_comb begin
    case (cfg_q.len)
      LEN_4:   len_words = BW'(4);
      LEN_8:   len_words = BW'(8);
      default: len_words = BW'(16);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lat_q    <= '0;
      cur_q    <= '0;
      cfg_q    <= '0;
      beat_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (ce_n) begin
      st_q     <= ST_IDLE;
      rd_valid <= 1'b0;
    end else if (start) begin
      st_q     <= ST_WAIT;
      lat_q    <= LW'(LATENCY - 1);
      cur_q    <= addr;
      cfg_q    <= cfg_in;
      beat_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (lat_q == '0) begin
            st_q     <= ST_BURST;
            rd_data  <= word;
            rd_valid <= 1'b1;
            cur_q    <= nxt_addr;
            beat_q   <= BW'(1);
          end else begin
            lat_q <= lat_q - LW'(1);
          end
        end
        ST_BURST: begin
          if (cfg_q.len != LEN_CONT && beat_q == len_words) begin
            st_q     <= ST_IDLE;
            rd_valid <= 1'b0;
          end else begin
            rd_data  <= word;
            rd_valid <= 1'b1;
            cur_q    <= nxt_addr;
            beat_q   <= beat_q + BW'(1);
          end
        end
        default: rd_valid <= 1'b0;
      endcase
    end
  end

  assign wait_o = (st_q == ST_WAIT);

  AST_WAIT_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_o && rd_valid)); // R4
  AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ce_n) |=> (wait_o && !rd_valid)); // R9
  AST_CE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!rd_valid && !wait_o)); // R8
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cfg_q.len != LEN_CONT) |-> (beat_q <= len_words)); // R5
  AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST && cfg_q.wrap && cfg_q.len == LEN_4 && !start && !ce_n)
      |-> (nxt_addr[AW-1:2] == cur_q[AW-1:2])); // R6
  AST_NOSYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !cfg_in.sync_en) |=> !wait_o); // R2
endmodule

// File: tb/tb_flb_burst_seq.sv
module tb_flb_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [5:0] cfg = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, wait_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  flb_burst_seq #(.AW(AW), .DW(DW), .LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .addr(addr), .cfg(cfg), .rd_data(rd_data), .rd_valid(rd_valid), .wait_o(wait_o)
  );

  // behavioural reference: 0 idle, 1 latency, 2 streaming
  int m_st, m_cnt, m_addr, m_beat, m_len, m_wrap, m_src, m_data;
  bit m_held, m_valid;

  function automatic int m_word(int src, int a);
    case (src)
      0: return (a ^ 'hC3A5) & 'hFFFF;
      1: return 'h0080;
      2: return 'h3C00 | (a & 'hFF);
      default: return 'h5100 | (a & 'hFF);
    endcase
  endfunction

  function automatic int m_next(int a, int len, int wrap);
    if (wrap != 0 && len != 0) return (a / len) * len + ((a + 1) % len);
    return (a + 1) % 65536;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_valid = 0; m_data = 0; m_held = 0;
    end else if (ce_n) begin
      m_st = 0; m_valid = 0; m_held = 0;
    end else begin
      bit go;
      go = !adv_n && we_n && cfg[0] && !m_held;
      m_held = !adv_n && (m_held || go);
      if (go) begin
        m_st = 1; m_cnt = LAT - 1; m_addr = int'(addr);
        m_len = (cfg[2:1] == 3) ? 0 : (4 << cfg[2:1]);
        m_wrap = int'(cfg[3]); m_src = int'(cfg[5:4]);
        m_valid = 0; m_beat = 0;
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin
          m_st = 2; m_data = m_word(m_src, m_addr); m_valid = 1;
          m_addr = m_next(m_addr, m_len, m_wrap); m_beat = 1;
        end else m_cnt--;
      end else if (m_st == 2) begin
        if (m_len != 0 && m_beat == m_len) begin
          m_st = 0; m_valid = 0;
        end else begin
          m_data = m_word(m_src, m_addr); m_valid = 1;
          m_addr = m_next(m_addr, m_len, m_wrap); m_beat++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rd_valid !== m_valid || (m_valid && int'(rd_data) != m_data)) begin
        fails++;
        $display("FAIL %s valid/data act=%0b/%h exp=%0b/%h", cur_req, rd_valid, rd_data, m_valid, m_data[15:0]);
      end
      checks++;
      if (wait_o !== (m_st == 1)) begin
        fails++;
        $display("FAIL R4 wait act=%0b exp=%0b", wait_o, (m_st == 1));
      end
    end
  end

  task automatic pulse(input logic [AW-1:0] a, input logic [5:0] c);
    @(negedge clk); ce_n = 0; addr = a; cfg = c; adv_n = 0;
    @(negedge clk); adv_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic close_ce();
    @(negedge clk); ce_n = 1; adv_n = 1;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    checks++;
    if (rd_valid !== 0 || wait_o !== 0 || rd_data !== 0) begin
      fails++;
      $display("FAIL R1 reset act=%0b/%0b/%h exp=0/0/0000", rd_valid, wait_o, rd_data);
    end
    rst_n = 1;
    idle(2);

    cur_req = "R2";                                   // sync disabled, then write enable low
    pulse(16'h0100, 6'b000_000); idle(8);
    @(negedge clk); we_n = 0; adv_n = 0; cfg = 6'b000_001;
    idle(3); @(negedge clk); adv_n = 1; we_n = 1; idle(6);
    close_ce();

    cur_req = "R5";                                   // 4 wrap array from 0x0102
    pulse(16'h0102, 6'b00_1_00_1); idle(10); close_ce();

    cur_req = "R3";                                   // held strobe, 8 linear
    @(negedge clk); ce_n = 0; addr = 16'h0206; cfg = 6'b00_0_01_1; adv_n = 0;
    idle(14); @(negedge clk); adv_n = 1; idle(2); close_ce();

    cur_req = "R6";                                   // 16 wrap near block end
    pulse(16'h00FA, 6'b00_1_10_1); idle(22); close_ce();

    cur_req = "R5";                                   // continuous across address top
    pulse(16'hFFFC, 6'b00_1_11_1); idle(26);
    cur_req = "R8"; close_ce();

    cur_req = "R8";                                   // abort mid fixed burst
    pulse(16'h0010, 6'b00_0_10_1); idle(6); close_ce();

    cur_req = "R7";
    pulse(16'h0033, 6'b01_0_00_1); idle(9); close_ce();
    pulse(16'h0047, 6'b10_0_00_1); idle(9); close_ce();
    pulse(16'h0059, 6'b11_1_00_1); idle(9); close_ce();

    cur_req = "R9";                                   // capture on last-beat edge
    pulse(16'h0040, 6'b00_0_00_1); idle(LAT + 1);
    pulse(16'h0080, 6'b00_0_00_1); idle(10); close_ce();

    cur_req = "R10";                                  // cfg change mid access
    pulse(16'h0123, 6'b00_1_01_1);
    @(negedge clk); cfg = 6'b01_0_00_1; idle(12); close_ce();

    cur_req = "R3";                                   // held, released one cycle, low again
    @(negedge clk); ce_n = 0; addr = 16'h0300; cfg = 6'b00_0_00_1; adv_n = 0;
    idle(1); @(negedge clk); adv_n = 1;
    @(negedge clk); adv_n = 0; addr = 16'h0500; idle(10);
    @(negedge clk); adv_n = 1; close_ce();

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule